// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which interrupt a PC-style serial port reports to the processor and when it raises its request line. Five sources compete in a fixed priority order: receiver line errors, received data at or above the FIFO trigger level, a receive character timeout, an empty transmit holding buffer, and modem-status changes. Each source counts only when its enable bit is set. The winning source is registered as a 4-bit identification code. A read of the identification register sees that code with the two top bits forced high. The request output is high whenever a source is active.

The block holds two pieces of state of its own. The first is a character-timeout counter. It advances on each timing tick while received data is waiting, and it restarts whenever a character enters or leaves the receive FIFO. A timeout is flagged once the counter reaches a fixed multiple of the character time. The second is a transmit-empty pending flag. A holding-to-shift transfer sets it. A write to the holding register clears it, and so does an identification read while the transmit-empty interrupt is enabled. The FIFOs and the serializer live outside this block. They report to it through level inputs and single-cycle strobes.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `iir_rdata` reads 0xC1, `irq` is low and the transmit-empty pending flag is set.
- R2: `iir_rdata[7:6]` are always 1, `iir_rdata[5:4]` are always 0, and `iir_rdata[3:0]` is the identification code. Code 0x1 means no interrupt. `irq` is high exactly when `iir_rdata[0]` is 0.
- R3: When several sources are active, the highest-priority one wins. The order and codes, from highest to lowest, are: line error 0x6, received data 0x4, character timeout 0xC, transmit empty 0x2, modem change 0x0.
- R4: `ier` bit 0 enables both received data and character timeout. Bit 1 enables transmit empty, bit 2 enables line error and bit 3 enables modem change. A source whose enable is clear has no effect on the code.
- R5: The line error source is active when any bit of `line_err` is set. The modem change source is active when any bit of `msr_delta` is set.
- R6: The received-data source is active when `rx_ready` is high and `rx_count` is at or above the level that `trig_sel` selects: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14.
- R7: The timeout counter adds one on each clock with `tick` high while `rx_ready` is high, and holds its value otherwise. The timeout source is active once the counter is at least `TO_MULT * char_time`.
- R8: A pulse on `rx_push` or `rx_read` returns the timeout counter to zero.
- R9: The transmit-empty source is active only when `thr_empty` is high and the pending flag is set.
- R10: `thr_xfer` sets the pending flag. `thr_write` clears it, and so does `iir_read` while `ier` bit 1 is set. A clear in the same cycle as `thr_xfer` wins.
- R11: `iir_read` while `ier` bit 1 is clear leaves the pending flag unchanged.
- R12: The code reflects the inputs sampled at the previous clock edge, so an input change shows on `iir_rdata` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timing tick that advances the timeout counter |
| ier | input | 4 | Interrupt enables (bit 0 rx data/timeout, 1 tx empty, 2 line, 3 modem) |
| rx_ready | input | 1 | Receive data ready |
| line_err | input | 4 | Overrun, parity, framing and break flags |
| thr_empty | input | 1 | Transmit holding buffer empty |
| msr_delta | input | 4 | Modem-status change flags |
| rx_count | input | CNT_W | Characters in the receive FIFO |
| trig_sel | input | 2 | Receive trigger-level select |
| char_time | input | CT_W | Ticks per character frame |
| rx_read | input | 1 | Strobe: a character was read from the receive FIFO |
| rx_push | input | 1 | Strobe: a character was pushed into the receive FIFO |
| thr_write | input | 1 | Strobe: the holding register was written |
| thr_xfer | input | 1 | Strobe: holding buffer moved to the shift register |
| iir_read | input | 1 | Strobe: the identification register was read |
| iir_rdata | output | 8 | Identification register read value |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the character timeout. It cannot be set directly. It needs data waiting, a receive trigger level that the FIFO count does not meet, and a run of ticks long enough to reach the limit, with no push or read in between. The stimulus first restarts the counter with a push strobe and uses a short character time. It then applies single ticks one at a time and checks the code after each, so the exact tick that crosses the limit is seen. Further runs show that a read restarts the count and that ticks without waiting data do not advance it.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    typedef enum logic [3:0] {
        IID_MODEM   = 4'h0,
        IID_NONE    = 4'h1,
        IID_THRE    = 4'h2,
        IID_RXDATA  = 4'h4,
        IID_LINE    = 4'h6,
        IID_TIMEOUT = 4'hC
    } iid_e;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic timeout;
        logic thre;
        logic modem;
    } src_t;

    typedef struct packed {
        iid_e iid;
    } ident_state_t;

    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/uirq_timeout.sv
module uirq_timeout #(
    parameter int CT_W    = 8,
    parameter int TO_MULT = 4,
    parameter int TO_W    = CT_W + $clog2(TO_MULT) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            data_ready,
    input  logic            restart,
    input  logic [CT_W-1:0] char_time,
    output logic            timed_out,
    output logic [TO_W-1:0] count
);
    logic [TO_W-1:0] cnt_d, cnt_q;
    logic [TO_W-1:0] limit;

    assign limit = TO_W'(char_time) * TO_W'(TO_MULT);

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = '0;
        else if (tick && data_ready && (cnt_q != '1))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign timed_out = (cnt_q >= limit);
    assign count     = cnt_q;
endmodule

// File: rtl/uirq_thre.sv
module uirq_thre (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic pend
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr_evt)      pend_d = 1'b0;
        else if (set_evt) pend_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b1;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  src_t src,
    output iid_e code
);
    always_comb begin
        if (src.line)         code = IID_LINE;
        else if (src.rxdata)  code = IID_RXDATA;
        else if (src.timeout) code = IID_TIMEOUT;
        else if (src.thre)    code = IID_THRE;
        else if (src.modem)   code = IID_MODEM;
        else                  code = IID_NONE;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uirq_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int CT_W    = 8,
    parameter int TO_MULT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [3:0]       ier,
    input  logic             rx_ready,
    input  logic [3:0]       line_err,
    input  logic             thr_empty,
    input  logic [3:0]       msr_delta,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic [CT_W-1:0]  char_time,
    input  logic             rx_read,
    input  logic             rx_push,
    input  logic             thr_write,
    input  logic             thr_xfer,
    input  logic             iir_read,
    output logic [7:0]       iir_rdata,
    output logic             irq
);
    localparam int TO_W  = CT_W + $clog2(TO_MULT) + 1;
    localparam int CMP_W = (CNT_W > 5) ? CNT_W : 5;

    logic            timed_out;
    logic [TO_W-1:0] to_count;
    logic            thre_pend;
    src_t            src;
    iid_e            code;
    ident_state_t    st_d, st_q;

    uirq_timeout #(.CT_W(CT_W), .TO_MULT(TO_MULT), .TO_W(TO_W)) u_timeout (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .data_ready (rx_ready),
        .restart    (rx_push | rx_read),
        .char_time  (char_time),
        .timed_out  (timed_out),
        .count      (to_count)
    );

    uirq_thre u_thre (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (thr_xfer),
        .clr_evt (thr_write | (iir_read & ier[1])),
        .pend    (thre_pend)
    );

    always_comb begin
        src.line    = ier[2] & (|line_err);
        src.rxdata  = ier[0] & rx_ready &
                      (CMP_W'(rx_count) >= CMP_W'(trig_level(trig_sel)));
        src.timeout = ier[0] & timed_out;
        src.thre    = ier[1] & thr_empty & thre_pend;
        src.modem   = ier[3] & (|msr_delta);
    end

    uirq_prio u_prio (
        .src  (src),
        .code (code)
    );

    always_comb begin
        st_d     = st_q;
        st_d.iid = code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{iid: IID_NONE};
        else        st_q <= st_d;
    end

    assign iir_rdata = {4'b1100, st_q.iid};
    assign irq       = ~st_q.iid[0];
endmodule

// File: rtl/uirq_ident_chk.sv
module uirq_ident_chk #(
    parameter int CT_W    = 8,
    parameter int TO_MULT = 4,
    parameter int TO_W    = CT_W + $clog2(TO_MULT) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic [3:0]      ier,
    input logic            rx_ready,
    input logic [3:0]      line_err,
    input logic            rx_read,
    input logic            rx_push,
    input logic            thr_write,
    input logic            iir_read,
    input logic [7:0]      iir_rdata,
    input logic [TO_W-1:0] to_count,
    input logic            thre_pend
);
    // R3
    line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[2] && (|line_err)) |=> (iir_rdata[3:0] == 4'h6));

    // R4
    all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == 4'h0) |=> (iir_rdata[3:0] == 4'h1));

    // R8
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || rx_read) |=> (to_count == '0));

    // R7
    tick_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rx_ready && !rx_push && !rx_read && (to_count != '1))
        |=> (to_count == $past(to_count) + 1'b1));

    // R10
    write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_write |=> !thre_pend);

    // R11
    masked_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_read && !ier[1] && !thr_write && thre_pend) |=> thre_pend);
endmodule

bind uart_irq_ident uirq_ident_chk #(.CT_W(CT_W), .TO_MULT(TO_MULT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ier       (ier),
    .rx_ready  (rx_ready),
    .line_err  (line_err),
    .rx_read   (rx_read),
    .rx_push   (rx_push),
    .thr_write (thr_write),
    .iir_read  (iir_read),
    .iir_rdata (iir_rdata),
    .to_count  (to_count),
    .thre_pend (thre_pend)
);

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;
    localparam int CNT_W = 5;
    localparam int CT_W  = 8;
    localparam int TO_MULT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [3:0] ier = '0;
    logic rx_ready = 1'b0;
    logic [3:0] line_err = '0;
    logic thr_empty = 1'b0;
    logic [3:0] msr_delta = '0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [1:0] trig_sel = '0;
    logic [CT_W-1:0] char_time = 8'd2;
    logic rx_read = 1'b0, rx_push = 1'b0, thr_write = 1'b0, thr_xfer = 1'b0, iir_read = 1'b0;
    logic [7:0] iir_rdata;
    logic irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_irq_ident #(.CNT_W(CNT_W), .CT_W(CT_W), .TO_MULT(TO_MULT)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ier(ier), .rx_ready(rx_ready),
        .line_err(line_err), .thr_empty(thr_empty), .msr_delta(msr_delta),
        .rx_count(rx_count), .trig_sel(trig_sel), .char_time(char_time),
        .rx_read(rx_read), .rx_push(rx_push), .thr_write(thr_write),
        .thr_xfer(thr_xfer), .iir_read(iir_read), .iir_rdata(iir_rdata), .irq(irq)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual {irq,iir}=%h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] expect_of(input logic [3:0] code);
        return {~code[0], 4'hC, code};
    endfunction

    function automatic logic [3:0] exp_code(input logic [3:0] en, input bit ls, input bit rd,
                                            input bit to, input bit th, input bit ms);
        if (en[2] && ls)      return 4'h6;
        else if (en[0] && rd) return 4'h4;
        else if (en[0] && to) return 4'hC;
        else if (en[1] && th) return 4'h2;
        else if (en[3] && ms) return 4'h0;
        else                  return 4'h1;
    endfunction

    function automatic int lvl(input int s);
        case (s)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic pulse_push();
        rx_push = 1'b1; cyc(1); rx_push = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        chk("R1", {irq, iir_rdata}, 9'h0C1);

        // R3 R4 R5 R6 R9 R2: sweep over the source combinations and enable masks.
        // The timeout source stays idle because no tick arrives.
        for (int m = 0; m < 16; m++) begin
            for (int e = 0; e < 16; e++) begin
                ier       = 4'(e);
                line_err  = m[0] ? (4'b0001 << (e % 4)) : 4'b0000;
                rx_ready  = m[1];
                rx_count  = m[1] ? 5'd1 : 5'd0;
                thr_empty = m[2];
                msr_delta = m[3] ? (4'b0001 << (m % 4)) : 4'b0000;
                cyc(1);
                chk("R3/R4 priority sweep", {irq, iir_rdata},
                    expect_of(exp_code(4'(e), m[0], m[1], 1'b0, m[2], m[3])));
            end
        end
        line_err = '0; msr_delta = '0; thr_empty = 1'b0;

        // R6: trigger-level sweep
        char_time = 8'd255;
        ier = 4'h1; rx_ready = 1'b1;
        pulse_push();
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 17; c++) begin
                trig_sel = 2'(s);
                rx_count = 5'(c);
                cyc(1);
                chk("R6 trigger level", {irq, iir_rdata},
                    expect_of((c >= lvl(s)) ? 4'h4 : 4'h1));
            end
        end

        // R7: character timeout, limit = TO_MULT * 2 = 8
        char_time = 8'd2; trig_sel = 2'd0; rx_count = 5'd0;
        pulse_push();
        for (int n = 1; n <= 10; n++) begin
            tick = 1'b1; cyc(1); tick = 1'b0; cyc(1);
            chk("R7 timeout count", {irq, iir_rdata}, expect_of((n >= 8) ? 4'hC : 4'h1));
        end
        // R8: a read restarts the counter
        rx_read = 1'b1; cyc(1); rx_read = 1'b0; cyc(1);
        chk("R8 read restarts", {irq, iir_rdata}, expect_of(4'h1));
        // R7: ticks without waiting data do not advance the counter
        rx_ready = 1'b0;
        for (int n = 0; n < 10; n++) begin
            tick = 1'b1; cyc(1); tick = 1'b0;
        end
        rx_ready = 1'b1; cyc(1);
        chk("R7 hold without data", {irq, iir_rdata}, expect_of(4'h1));
        for (int n = 1; n <= 8; n++) begin
            tick = 1'b1; cyc(1); tick = 1'b0; cyc(1);
            chk("R7 recount", {irq, iir_rdata}, expect_of((n >= 8) ? 4'hC : 4'h1));
        end
        // R8: a push restarts the counter
        pulse_push(); cyc(1);
        chk("R8 push restarts", {irq, iir_rdata}, expect_of(4'h1));
        rx_ready = 1'b0;

        // R9 R10 R11: transmit-empty pending flag
        ier = 4'h2; thr_empty = 1'b1; cyc(1);
        chk("R9 pending after reset", {irq, iir_rdata}, expect_of(4'h2));
        thr_write = 1'b1; cyc(1); thr_write = 1'b0; cyc(1);
        chk("R10 write clears", {irq, iir_rdata}, expect_of(4'h1));
        thr_xfer = 1'b1; cyc(1); thr_xfer = 1'b0; cyc(1);
        chk("R10 transfer sets", {irq, iir_rdata}, expect_of(4'h2));
        iir_read = 1'b1; cyc(1); iir_read = 1'b0; cyc(1);
        chk("R10 read clears", {irq, iir_rdata}, expect_of(4'h1));
        thr_xfer = 1'b1; cyc(1); thr_xfer = 1'b0; cyc(1);
        ier = 4'h0; iir_read = 1'b1; cyc(1); iir_read = 1'b0;
        ier = 4'h2; cyc(1);
        chk("R11 masked read keeps", {irq, iir_rdata}, expect_of(4'h2));
        thr_empty = 1'b0; cyc(1);
        chk("R9 needs holding empty", {irq, iir_rdata}, expect_of(4'h1));
        thr_empty = 1'b1;
        thr_write = 1'b1; thr_xfer = 1'b1; cyc(1); thr_write = 1'b0; thr_xfer = 1'b0; cyc(1);
        chk("R10 write beats transfer", {irq, iir_rdata}, expect_of(4'h1));
        thr_xfer = 1'b1; cyc(1); thr_xfer = 1'b0; cyc(1);
        iir_read = 1'b1; thr_xfer = 1'b1; cyc(1); iir_read = 1'b0; thr_xfer = 1'b0; cyc(1);
        chk("R10 read beats transfer", {irq, iir_rdata}, expect_of(4'h1));
        thr_empty = 1'b0;

        // R12: one-cycle latency from input to code
        ier = 4'h4; cyc(1);
        line_err = 4'b0010;
        #0;
        chk("R12 before edge", {irq, iir_rdata}, expect_of(4'h1));
        cyc(1);
        chk("R12 after edge", {irq, iir_rdata}, expect_of(4'h6));
        line_err = 4'b0000; cyc(1);
        chk("R2 no interrupt code", {irq, iir_rdata}, 9'h0C1);

        finish_run();
    end
endmodule